// File: doc/BRIEF.md
# Runahead Checkpoint and Invalid-Bit Tracker

This block lets an in-order pipeline keep running instructions while a data-cache miss is outstanding, so that later misses can be found early. When a stalling miss arrives, it copies the live register bank into a shadow bank and keeps the program counter of the faulting load. The destination of that load starts out invalid.

While the block is speculating, it watches each decoded instruction. It keeps one invalid flag per register and one per cache line. For every ALU operation and every load, it reports one cycle later whether the destination became invalid. Stores with a good address that would hit mark their line invalid. In conservative mode, a conditional branch on an invalid register freezes speculation. Exceptions raised while speculating are suppressed and only counted.

When the fill event arrives, the register bank is restored from the shadow copy in one cycle. All invalid flags are cleared, and a one-cycle redirect pulse carries the saved program counter back to fetch.

Top module: `ra_ckpt_tracker`

## Requirements
- R1: After reset, `runahead_o`, `halted_o`, `dest_inv_valid_o`, `restore_o` and `redirect_valid_o` are 0, and `reg_inv_o` and `excp_cnt_o` are all zero.
- R2: In normal mode, a cycle with `miss_stall_i`=1 makes `runahead_o` 1 in the next cycle. In that cycle `reg_inv_o` has only bit `miss_rd_i` set. `miss_stall_i` is ignored while already speculating.
- R3: Register writes made while speculating are undone at the fill. The next cycle after the fill, every register reads back the value it held when speculation began. `restore_o` is high in that cycle only.
- R4: For an ALU instruction (`instr_op_i`=1) while speculating, the destination flag becomes the OR of the flags of `rs1` and `rs2`. It is cleared when both are valid. The result appears on `dest_inv_o` with `dest_inv_valid_o`=1 in the next cycle.
- R5: For a load (`instr_op_i`=2) while speculating, the destination becomes invalid if any of these holds: the address register `rs1` is invalid, `instr_miss_i`=1, or the line `instr_line_i` is marked invalid. Otherwise it is valid. The result is reported as in R4.
- R6: A store (`instr_op_i`=3) while speculating marks line `instr_line_i` invalid only when `rs1` is valid and `instr_miss_i`=0. A store produces no destination report.
- R7: With `conservative_i`=1, a branch (`instr_op_i`=4) whose `rs1` is invalid sets `halted_o` in the next cycle. Until the fill, later instructions then change no flags and produce no reports. With `conservative_i`=0, such a branch does not halt.
- R8: A fill while speculating drives `redirect_valid_o` high for exactly one cycle, with `redirect_pc_o` equal to the saved faulting address. In that same cycle `runahead_o` and `halted_o` are 0, and all register and line flags are clear.
- R9: An instruction or register write presented in the same cycle as the fill is discarded. It produces no report, and the restored values win.
- R10: Each instruction with `instr_excp_i`=1 that is processed while speculating, and not halted, increments `excp_cnt_o`. The count saturates at its maximum and survives across episodes.
- R11: In normal mode, instructions produce no destination report and leave `reg_inv_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conservative_i | input | 1 | 1: halt on branch with invalid condition |
| miss_stall_i | input | 1 | Stalling primary data-cache miss |
| miss_pc_i | input | PCW | Address of the faulting load |
| miss_rd_i | input | log2(NREG) | Destination register of the faulting load |
| fill_i | input | 1 | The outstanding miss has been serviced |
| instr_valid_i | input | 1 | Decoded instruction present |
| instr_op_i | input | 3 | 0 none, 1 ALU, 2 load, 3 store, 4 branch |
| instr_rd_i | input | log2(NREG) | Destination register |
| instr_rs1_i | input | log2(NREG) | Source / address / condition register |
| instr_rs2_i | input | log2(NREG) | Second ALU source |
| instr_line_i | input | log2(LINES) | Cache line index of a load or store |
| instr_miss_i | input | 1 | The access would miss in the cache |
| instr_excp_i | input | 1 | The instruction raised an exception |
| wr_en_i | input | 1 | Register write from the pipeline |
| wr_idx_i | input | log2(NREG) | Register to write |
| wr_data_i | input | XLEN | Write data |
| rd_idx_i | input | log2(NREG) | Register to read |
| rd_data_o | output | XLEN | Read data, combinational |
| runahead_o | output | 1 | Speculating |
| halted_o | output | 1 | Speculation frozen at a branch |
| reg_inv_o | output | NREG | Register invalid flags |
| dest_inv_valid_o | output | 1 | Destination report valid |
| dest_inv_o | output | 1 | Reported destination is invalid |
| restore_o | output | 1 | Register bank restored this cycle |
| redirect_valid_o | output | 1 | Redirect fetch pulse |
| redirect_pc_o | output | PCW | Redirect target |
| excp_cnt_o | output | CNTW | Suppressed exception count |

## Verification
Two functions can fall in the same cycle: the fill that ends speculation, and the processing of a presented instruction together with a pipeline register write. The bench drives the fill in the same cycle as an ALU operation on an invalid source and a write to a register. The fill must win. The scoreboard must see no destination report, all flags must read zero, and the written register must read back its pre-speculation value. A second overlap is checked as well: a stalling miss that arrives while already speculating must leave the saved redirect address unchanged.

// File: rtl/ra_pkg.sv
package ra_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_ALU    = 3'd1,
        OP_LOAD   = 3'd2,
        OP_STORE  = 3'd3,
        OP_BRANCH = 3'd4
    } ra_op_e;
endpackage

// File: rtl/ra_mode_ctl.sv
module ra_mode_ctl #(
    parameter int PCW  = 16,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            miss_stall_i,
    input  logic [PCW-1:0]  miss_pc_i,
    input  logic            fill_i,
    input  logic            conservative_i,
    input  logic            br_inv_i,
    input  logic            excp_i,
    output logic            run_o,
    output logic            halted_o,
    output logic            enter_o,
    output logic            exit_o,
    output logic            active_o,
    output logic            redirect_o,
    output logic [PCW-1:0]  redirect_pc_o,
    output logic            restore_o,
    output logic [CNTW-1:0] excp_cnt_o
);
    localparam logic [CNTW-1:0] CNT_MAX = {CNTW{1'b1}};

    typedef struct packed {
        logic            run;
        logic            halted;
        logic [PCW-1:0]  pc;
        logic            redir;
        logic            rest;
        logic [CNTW-1:0] cnt;
    } mode_t;

    mode_t d, q;

    always_comb begin
        d       = q;
        d.redir = 1'b0;
        d.rest  = 1'b0;
        if (!q.run) begin
            if (miss_stall_i) begin
                d.run    = 1'b1;
                d.halted = 1'b0;
                d.pc     = miss_pc_i;
            end
        end else if (fill_i) begin
            d.run    = 1'b0;
            d.halted = 1'b0;
            d.redir  = 1'b1;
            d.rest   = 1'b1;
        end else if (!q.halted) begin
            if (excp_i && (q.cnt != CNT_MAX)) begin
                d.cnt = q.cnt + 1'b1;
            end
            if (br_inv_i && conservative_i) begin
                d.halted = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_o         = q.run;
    assign halted_o      = q.halted;
    assign enter_o       = !q.run && miss_stall_i;
    assign exit_o        = q.run && fill_i;
    assign active_o      = q.run && !q.halted && !fill_i;
    assign redirect_o    = q.redir;
    assign redirect_pc_o = q.pc;
    assign restore_o     = q.rest;
    assign excp_cnt_o    = q.cnt;

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && miss_stall_i) |=> run_o);
    assert_halt_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> run_o);
    assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && fill_i) |=> (redirect_o && !run_o && !halted_o));
    assert_redirect_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);
    assert_cnt_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (excp_cnt_o == CNT_MAX) |=> (excp_cnt_o == CNT_MAX));
endmodule

// File: rtl/ra_regbank.sv
module ra_regbank #(
    parameter int NREG = 8,
    parameter int XLEN = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [$clog2(NREG)-1:0] wr_idx_i,
    input  logic [XLEN-1:0]         wr_data_i,
    input  logic                    ckpt_i,
    input  logic                    restore_i,
    input  logic [$clog2(NREG)-1:0] rd_idx_i,
    output logic [XLEN-1:0]         rd_data_o
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
        logic [NREG-1:0][XLEN-1:0] bak;
    } bank_t;

    bank_t d, q;

    always_comb begin
        d = q;
        if (restore_i) begin
            d.regs = q.bak;
        end else begin
            if (wr_en_i) begin
                d.regs[wr_idx_i] = wr_data_i;
            end
            if (ckpt_i) begin
                d.bak = d.regs;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data_o = q.regs[rd_idx_i];

    assert_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (q.regs == $past(q.bak)));
endmodule

// File: rtl/ra_inv_track.sv
module ra_inv_track #(
    parameter int NREG  = 8,
    parameter int LINES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  ra_pkg::ra_op_e           op_i,
    input  logic [$clog2(NREG)-1:0]  rd_i,
    input  logic [$clog2(NREG)-1:0]  rs1_i,
    input  logic [$clog2(NREG)-1:0]  rs2_i,
    input  logic [$clog2(LINES)-1:0] line_i,
    input  logic                     mem_miss_i,
    input  logic                     active_i,
    input  logic                     enter_i,
    input  logic [$clog2(NREG)-1:0]  miss_rd_i,
    input  logic                     clear_i,
    output logic [NREG-1:0]          reg_inv_o,
    output logic                     dest_vld_o,
    output logic                     dest_inv_o,
    output logic                     br_inv_o
);
    import ra_pkg::*;

    typedef struct packed {
        logic [NREG-1:0]  rinv;
        logic [LINES-1:0] linv;
        logic             dvld;
        logic             dinv;
    } trk_t;

    trk_t d, q;
    logic flag;

    always_comb begin
        d      = q;
        d.dvld = 1'b0;
        d.dinv = 1'b0;
        flag   = 1'b0;
        if (clear_i) begin
            d.rinv = '0;
            d.linv = '0;
        end else if (enter_i) begin
            d.rinv            = '0;
            d.rinv[miss_rd_i] = 1'b1;
        end else if (active_i && valid_i) begin
            case (op_i)
                OP_ALU: begin
                    flag         = q.rinv[rs1_i] | q.rinv[rs2_i];
                    d.rinv[rd_i] = flag;
                    d.dvld       = 1'b1;
                    d.dinv       = flag;
                end
                OP_LOAD: begin
                    flag         = q.rinv[rs1_i] | mem_miss_i | q.linv[line_i];
                    d.rinv[rd_i] = flag;
                    d.dvld       = 1'b1;
                    d.dinv       = flag;
                end
                OP_STORE: begin
                    if (!q.rinv[rs1_i] && !mem_miss_i) begin
                        d.linv[line_i] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign reg_inv_o  = q.rinv;
    assign dest_vld_o = q.dvld;
    assign dest_inv_o = q.dinv;
    assign br_inv_o   = valid_i && (op_i == OP_BRANCH) && q.rinv[rs1_i];

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (reg_inv_o == '0));
    assert_alu_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && valid_i && op_i == OP_ALU && !q.rinv[rs1_i] && !q.rinv[rs2_i])
        |=> (dest_vld_o && !dest_inv_o));
    assert_load_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && valid_i && op_i == OP_LOAD && mem_miss_i) |=> (dest_vld_o && dest_inv_o));
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !dest_vld_o);
endmodule

// File: rtl/ra_ckpt_tracker.sv
module ra_ckpt_tracker #(
    parameter int NREG  = 8,
    parameter int XLEN  = 16,
    parameter int PCW   = 16,
    parameter int LINES = 64,
    parameter int CNTW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     conservative_i,
    input  logic                     miss_stall_i,
    input  logic [PCW-1:0]           miss_pc_i,
    input  logic [$clog2(NREG)-1:0]  miss_rd_i,
    input  logic                     fill_i,
    input  logic                     instr_valid_i,
    input  logic [2:0]               instr_op_i,
    input  logic [$clog2(NREG)-1:0]  instr_rd_i,
    input  logic [$clog2(NREG)-1:0]  instr_rs1_i,
    input  logic [$clog2(NREG)-1:0]  instr_rs2_i,
    input  logic [$clog2(LINES)-1:0] instr_line_i,
    input  logic                     instr_miss_i,
    input  logic                     instr_excp_i,
    input  logic                     wr_en_i,
    input  logic [$clog2(NREG)-1:0]  wr_idx_i,
    input  logic [XLEN-1:0]          wr_data_i,
    input  logic [$clog2(NREG)-1:0]  rd_idx_i,
    output logic [XLEN-1:0]          rd_data_o,
    output logic                     runahead_o,
    output logic                     halted_o,
    output logic [NREG-1:0]          reg_inv_o,
    output logic                     dest_inv_valid_o,
    output logic                     dest_inv_o,
    output logic                     restore_o,
    output logic                     redirect_valid_o,
    output logic [PCW-1:0]           redirect_pc_o,
    output logic [CNTW-1:0]          excp_cnt_o
);
    import ra_pkg::*;

    ra_op_e op_w;
    logic   enter_w, exit_w, active_w, br_inv_w;

    assign op_w = ra_op_e'(instr_op_i);

    ra_mode_ctl #(.PCW(PCW), .CNTW(CNTW)) u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_stall_i   (miss_stall_i),
        .miss_pc_i      (miss_pc_i),
        .fill_i         (fill_i),
        .conservative_i (conservative_i),
        .br_inv_i       (br_inv_w),
        .excp_i         (instr_valid_i && instr_excp_i),
        .run_o          (runahead_o),
        .halted_o       (halted_o),
        .enter_o        (enter_w),
        .exit_o         (exit_w),
        .active_o       (active_w),
        .redirect_o     (redirect_valid_o),
        .redirect_pc_o  (redirect_pc_o),
        .restore_o      (restore_o),
        .excp_cnt_o     (excp_cnt_o)
    );

    ra_regbank #(.NREG(NREG), .XLEN(XLEN)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .ckpt_i    (enter_w),
        .restore_i (exit_w),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_data_o)
    );

    ra_inv_track #(.NREG(NREG), .LINES(LINES)) u_inv (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (instr_valid_i),
        .op_i       (op_w),
        .rd_i       (instr_rd_i),
        .rs1_i      (instr_rs1_i),
        .rs2_i      (instr_rs2_i),
        .line_i     (instr_line_i),
        .mem_miss_i (instr_miss_i),
        .active_i   (active_w),
        .enter_i    (enter_w),
        .miss_rd_i  (miss_rd_i),
        .clear_i    (exit_w),
        .reg_inv_o  (reg_inv_o),
        .dest_vld_o (dest_inv_valid_o),
        .dest_inv_o (dest_inv_o),
        .br_inv_o   (br_inv_w)
    );
endmodule

// File: tb/test_ra_ckpt_tracker.sv
module test_ra_ckpt_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conservative_i = 1'b0;
    logic        miss_stall_i = 1'b0;
    logic [15:0] miss_pc_i = '0;
    logic [2:0]  miss_rd_i = '0;
    logic        fill_i = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [2:0]  instr_op_i = '0;
    logic [2:0]  instr_rd_i = '0;
    logic [2:0]  instr_rs1_i = '0;
    logic [2:0]  instr_rs2_i = '0;
    logic [5:0]  instr_line_i = '0;
    logic        instr_miss_i = 1'b0;
    logic        instr_excp_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_idx_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [2:0]  rd_idx_i = '0;
    logic [15:0] rd_data_o;
    logic        runahead_o, halted_o, dest_inv_valid_o, dest_inv_o;
    logic        restore_o, redirect_valid_o;
    logic [7:0]  reg_inv_o;
    logic [15:0] redirect_pc_o;
    logic [7:0]  excp_cnt_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    int exp_req[$];
    bit exp_val[$];

    always #5 clk = ~clk;

    ra_ckpt_tracker i_ra_ckpt_tracker (
        .clk(clk), .rst_n(rst_n), .conservative_i(conservative_i),
        .miss_stall_i(miss_stall_i), .miss_pc_i(miss_pc_i), .miss_rd_i(miss_rd_i),
        .fill_i(fill_i), .instr_valid_i(instr_valid_i), .instr_op_i(instr_op_i),
        .instr_rd_i(instr_rd_i), .instr_rs1_i(instr_rs1_i), .instr_rs2_i(instr_rs2_i),
        .instr_line_i(instr_line_i), .instr_miss_i(instr_miss_i),
        .instr_excp_i(instr_excp_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_data_i(wr_data_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
        .runahead_o(runahead_o), .halted_o(halted_o), .reg_inv_o(reg_inv_o),
        .dest_inv_valid_o(dest_inv_valid_o), .dest_inv_o(dest_inv_o),
        .restore_o(restore_o), .redirect_valid_o(redirect_valid_o),
        .redirect_pc_o(redirect_pc_o), .excp_cnt_o(excp_cnt_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // driver: presents one instruction, pushes the expected report if any
    task automatic issue(input logic [2:0] op, input logic [2:0] rd, input logic [2:0] rs1,
                         input logic [2:0] rs2, input logic [5:0] line, input bit miss,
                         input bit excp, input bit has_out, input bit val, input int req);
        instr_valid_i = 1'b1;
        instr_op_i    = op;
        instr_rd_i    = rd;
        instr_rs1_i   = rs1;
        instr_rs2_i   = rs2;
        instr_line_i  = line;
        instr_miss_i  = miss;
        instr_excp_i  = excp;
        if (has_out) begin
            exp_req.push_back(req);
            exp_val.push_back(val);
        end
        tick();
        instr_valid_i = 1'b0;
        instr_excp_i  = 1'b0;
        instr_miss_i  = 1'b0;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] data);
        wr_en_i   = 1'b1;
        wr_idx_i  = idx;
        wr_data_i = data;
        tick();
        wr_en_i = 1'b0;
    endtask

    // monitor: every destination report must match the oldest expectation
    always @(posedge clk) begin
        #2;
        if (rst_n && dest_inv_valid_o) begin
            nchk++;
            if (exp_req.size() == 0) begin
                nfail++;
                $display("FAIL R7/R9/R11 unexpected report: actual %0b expected none", dest_inv_o);
            end else begin
                int r;
                bit v;
                r = exp_req.pop_front();
                v = exp_val.pop_front();
                if (dest_inv_o !== v) begin
                    nfail++;
                    $display("FAIL R%0d report: actual %0b expected %0b", r, dest_inv_o, v);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 runahead", {31'b0, runahead_o}, 0);
        chk("R1 halted", {31'b0, halted_o}, 0);
        chk("R1 reg_inv", {24'b0, reg_inv_o}, 0);
        chk("R1 redirect", {31'b0, redirect_valid_o}, 0);
        chk("R1 restore", {31'b0, restore_o}, 0);
        chk("R1 excp_cnt", {24'b0, excp_cnt_o}, 0);
        chk("R1 dest_valid", {31'b0, dest_inv_valid_o}, 0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < 8; i++) wr(3'(i), 16'h1000 + 16'(i));
        rd_idx_i = 3;
        #1;
        chk("R3 normal write", {16'b0, rd_data_o}, 32'h1003);

        // R11: normal mode, no reports
        issue(3'd2, 3'd3, 3'd0, 3'd0, 6'd1, 1'b1, 1'b0, 1'b0, 1'b0, 11);
        chk("R11 reg_inv normal", {24'b0, reg_inv_o}, 0);

        // R2 entry
        miss_stall_i = 1'b1; miss_pc_i = 16'h0400; miss_rd_i = 3'd2;
        tick();
        miss_stall_i = 1'b0;
        chk("R2 runahead", {31'b0, runahead_o}, 1);
        chk("R2 reg_inv entry", {24'b0, reg_inv_o}, 32'h04);

        wr(3'd5, 16'hDEAD);
        rd_idx_i = 5;
        #1;
        chk("R3 spec write visible", {16'b0, rd_data_o}, 32'hDEAD);

        issue(3'd1, 3'd3, 3'd2, 3'd1, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4);   // R4 invalid source
        chk("R4 reg_inv", {24'b0, reg_inv_o}, 32'h0C);
        issue(3'd1, 3'd3, 3'd0, 3'd1, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4);   // R4 cleared
        chk("R4 reg_inv cleared", {24'b0, reg_inv_o}, 32'h04);
        issue(3'd2, 3'd4, 3'd2, 3'd0, 6'd5, 1'b0, 1'b0, 1'b1, 1'b1, 5);   // R5 address invalid
        issue(3'd2, 3'd6, 3'd0, 3'd0, 6'd7, 1'b1, 1'b0, 1'b1, 1'b1, 5);   // R5 load miss
        issue(3'd2, 3'd7, 3'd0, 3'd0, 6'd9, 1'b0, 1'b0, 1'b1, 1'b0, 5);   // R5 clean
        issue(3'd3, 3'd0, 3'd0, 3'd0, 6'd9, 1'b0, 1'b0, 1'b0, 1'b0, 6);   // R6 marks line 9
        issue(3'd3, 3'd0, 3'd2, 3'd0, 6'd10, 1'b0, 1'b0, 1'b0, 1'b0, 6);  // R6 invalid address
        issue(3'd3, 3'd0, 3'd0, 3'd0, 6'd11, 1'b1, 1'b0, 1'b0, 1'b0, 6);  // R6 would miss
        issue(3'd2, 3'd7, 3'd0, 3'd0, 6'd9, 1'b0, 1'b0, 1'b1, 1'b1, 6);   // R6 line invalid
        issue(3'd2, 3'd1, 3'd0, 3'd0, 6'd10, 1'b0, 1'b0, 1'b1, 1'b0, 6);
        issue(3'd2, 3'd1, 3'd0, 3'd0, 6'd11, 1'b0, 1'b0, 1'b1, 1'b0, 6);
        chk("R5 reg_inv", {24'b0, reg_inv_o}, 32'hD4);
        issue(3'd4, 3'd0, 3'd2, 3'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 7);   // aggressive branch
        chk("R7 aggressive no halt", {31'b0, halted_o}, 0);
        issue(3'd1, 3'd0, 3'd0, 3'd0, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 10);
        chk("R10 excp_cnt", {24'b0, excp_cnt_o}, 1);

        // R9: fill, instruction and write in the same cycle
        fill_i = 1'b1; wr_en_i = 1'b1; wr_idx_i = 3'd6; wr_data_i = 16'hBEEF;
        issue(3'd1, 3'd0, 3'd2, 3'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 9);
        fill_i = 1'b0; wr_en_i = 1'b0;
        chk("R8 redirect", {31'b0, redirect_valid_o}, 1);
        chk("R8 redirect_pc", {16'b0, redirect_pc_o}, 32'h0400);
        chk("R8 runahead off", {31'b0, runahead_o}, 0);
        chk("R8 reg_inv clear", {24'b0, reg_inv_o}, 0);
        chk("R3 restore pulse", {31'b0, restore_o}, 1);
        rd_idx_i = 5;
        #1;
        chk("R3 r5 restored", {16'b0, rd_data_o}, 32'h1005);
        rd_idx_i = 6;
        #1;
        chk("R9 r6 write lost", {16'b0, rd_data_o}, 32'h1006);
        tick();
        chk("R8 redirect one cycle", {31'b0, redirect_valid_o}, 0);
        chk("R3 restore one cycle", {31'b0, restore_o}, 0);
        issue(3'd2, 3'd3, 3'd0, 3'd0, 6'd1, 1'b1, 1'b0, 1'b0, 1'b0, 11);
        chk("R11 normal after exit", {24'b0, reg_inv_o}, 0);

        // second episode: conservative
        conservative_i = 1'b1;
        miss_stall_i = 1'b1; miss_pc_i = 16'h0520; miss_rd_i = 3'd1;
        tick();
        miss_stall_i = 1'b0;
        chk("R2 reg_inv ep2", {24'b0, reg_inv_o}, 32'h02);
        issue(3'd2, 3'd2, 3'd0, 3'd0, 6'd9, 1'b0, 1'b0, 1'b1, 1'b0, 8);   // line table cleared
        issue(3'd4, 3'd0, 3'd1, 3'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 7);
        chk("R7 halted", {31'b0, halted_o}, 1);
        issue(3'd1, 3'd3, 3'd1, 3'd0, 6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 7);
        chk("R7 frozen reg_inv", {24'b0, reg_inv_o}, 32'h02);
        chk("R10 halted excp not counted", {24'b0, excp_cnt_o}, 1);
        miss_stall_i = 1'b1; miss_pc_i = 16'h0777;
        tick();
        miss_stall_i = 1'b0;
        fill_i = 1'b1;
        tick();
        fill_i = 1'b0;
        chk("R2 pc kept on second miss", {16'b0, redirect_pc_o}, 32'h0520);
        chk("R8 halted cleared", {31'b0, halted_o}, 0);

        // third episode: saturation
        conservative_i = 1'b0;
        miss_stall_i = 1'b1; miss_pc_i = 16'h0600; miss_rd_i = 3'd7;
        tick();
        miss_stall_i = 1'b0;
        for (int k = 0; k < 300; k++)
            issue(3'd1, 3'd0, 3'd0, 3'd0, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 10);
        chk("R10 saturated", {24'b0, excp_cnt_o}, 32'hFF);
        fill_i = 1'b1;
        tick();
        fill_i = 1'b0;
        chk("R10 kept after exit", {24'b0, excp_cnt_o}, 32'hFF);
        tick();
        tick();
        while (exp_req.size() != 0) begin
            int r;
            r = exp_req.pop_front();
            void'(exp_val.pop_front());
            nchk++;
            nfail++;
            $display("FAIL R%0d missing report: actual none expected one", r);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule